// File: doc/BRIEF.md
# Vector Length Setup and Element Sequencer

This block keeps the three pieces of state that describe a short scalable vector: the maximum element count, the current element count and the sub-vector group size. A set-length command loads the maximum count and the group size from immediate fields. In the same command it picks a requested length from one of three sources: an immediate, a general register value or the loop-count register. It clamps that request exactly to the smaller of request and maximum, stores the result, and returns it on a result port so the caller can write it back to a destination register.

Once the state is set up, a start pulse walks a hardware element loop. It issues one element per cycle in group-major order, walking each group's sub-elements before moving to the next group. One predicate bit, captured at start, gates every element of its group. A single-cycle done pulse closes the loop. A separate state-write port can also load the maximum count directly, outside the normal setup path.

Top module: `vec_len_seq`

## Requirements
- R1: After reset, maxLen, curLen and subLen read 0, and busy, done, resultValid and elemValid are low.
- R2: A setCmd accepted while idle loads maxLen from immMaxLen and subLen from immSubLen. The new values are visible on the next cycle. subLen encodes groups of 1 to 4 elements as values 0 to 3.
- R3: On an accepted setCmd, curLen becomes exactly MIN(request, immMaxLen). The comparison uses the full REQ_W-bit request with no truncation, so curLen <= maxLen always holds.
- R4: srcSel chooses the request: 1 selects regLen, 2 selects ctrLen, and 0 or 3 select immLen.
- R5: The cycle after an accepted setCmd, resultValid is high for exactly one cycle, and resultLen carries the clamped length zero-extended to REQ_W bits.
- R6: A stateWrEn accepted while idle (with setCmd and start low) sets maxLen to stateWrMax. It lowers curLen to stateWrMax only if curLen was larger, and it leaves subLen unchanged.
- R7: A start accepted while idle with curLen > 0 raises busy from the next cycle for curLen*(subLen+1) cycles. During those cycles elemGroup steps from 0 to curLen-1, and inside each group elemSub steps from 0 to subLen.
- R8: elemValid equals bit elemGroup of predMask as sampled at start. It is the same for every sub-element of a group, and changes to predMask during the loop have no effect.
- R9: done is high for exactly one cycle, the cycle after the last element, and busy is low in that cycle.
- R10: A start with curLen = 0 produces no element strobe, and done is high on the next cycle.
- R11: While busy, setCmd, stateWrEn and start are ignored: maxLen, curLen and subLen keep their values.
- R12: In one idle cycle, setCmd beats start, and start beats stateWrEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setCmd | input | 1 | Set-length command |
| srcSel | input | 2 | Request source select |
| immLen | input | REQ_W | Immediate requested length |
| regLen | input | REQ_W | Register-operand requested length |
| ctrLen | input | REQ_W | Loop-count register requested length |
| immMaxLen | input | MVL_W | Immediate maximum length |
| immSubLen | input | SUB_W | Immediate group size code |
| stateWrEn | input | 1 | Direct state write of the maximum length |
| stateWrMax | input | MVL_W | Value for the direct write |
| start | input | 1 | Start the element loop |
| predMask | input | 2**MVL_W | One predicate bit per group |
| maxLen | output | MVL_W | Maximum length state |
| curLen | output | MVL_W | Current vector length state |
| subLen | output | SUB_W | Group size code state |
| resultValid | output | 1 | Clamped result strobe |
| resultLen | output | REQ_W | Clamped length, zero-extended |
| busy | output | 1 | Loop running, one element per cycle |
| done | output | 1 | Loop finished pulse |
| elemValid | output | 1 | Current element enabled by its group predicate |
| elemGroup | output | MVL_W | Current group index |
| elemSub | output | SUB_W | Current sub-element index |

## Verification
The hardest conditions to reach from the ports are commands arriving while the loop runs, and predicate changes in mid-loop. To get there, the stimulus drives setCmd, stateWrEn, start and an inverted predMask on every cycle of a running loop, then checks that the element stream and the state are untouched. Requests wider than seven bits, chosen so that their low bits fall below the maximum, expose any clamp that truncates before it compares. Seeded random setups mix these cases with zero-length loops and direct writes that shrink the maximum below the current length.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_e;

  typedef struct packed {
    logic setLoad;
    logic wrMax;
    logic loopInit;
    logic subInc;
    logic grpInc;
  } ctrlStrobe_t;
endpackage

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        setCmd,
  input  logic        start,
  input  logic        stateWrEn,
  input  logic        lenZero,
  input  logic        lastSub,
  input  logic        lastGrp,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  seqState_e state;
  logic idle;
  logic finish;

  always_comb begin
    idle            = (state == ST_IDLE);
    strobe          = '0;
    strobe.setLoad  = idle && setCmd;
    strobe.loopInit = idle && !setCmd && start;
    strobe.wrMax    = idle && !setCmd && !start && stateWrEn;
    strobe.subInc   = busy && !lastSub;
    strobe.grpInc   = busy && lastSub && !lastGrp;
    finish          = busy && lastSub && lastGrp;
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (strobe.loopInit && lenZero) || finish;
      if (strobe.loopInit && !lenZero) state <= ST_RUN;
      else if (finish)                 state <= ST_IDLE;
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r10_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (idle && start && !setCmd && lenZero) |=> (done && !busy));
  a_r12_set_first: assert property (@(posedge clk) disable iff (!rstN)
    (idle && setCmd && start) |=> (!busy && !done));
endmodule

// File: rtl/vls_dp.sv
module vls_dp
  import vls_pkg::*;
#(
  parameter int MVL_W = 7,
  parameter int REQ_W = 16,
  parameter int SUB_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic                   busy,
  input  logic [1:0]             srcSel,
  input  logic [REQ_W-1:0]       immLen,
  input  logic [REQ_W-1:0]       regLen,
  input  logic [REQ_W-1:0]       ctrLen,
  input  logic [MVL_W-1:0]       immMaxLen,
  input  logic [SUB_W-1:0]       immSubLen,
  input  logic [MVL_W-1:0]       stateWrMax,
  input  logic [(1<<MVL_W)-1:0]  predMask,
  output logic [MVL_W-1:0]       maxLen,
  output logic [MVL_W-1:0]       curLen,
  output logic [SUB_W-1:0]       subLen,
  output logic                   resultValid,
  output logic [REQ_W-1:0]       resultLen,
  output logic [MVL_W-1:0]       elemGroup,
  output logic [SUB_W-1:0]       elemSub,
  output logic                   elemValid,
  output logic                   lenZero,
  output logic                   lastSub,
  output logic                   lastGrp
);
  localparam int NGRP = 1 << MVL_W;
  localparam int PAD  = REQ_W - MVL_W;
  localparam logic [MVL_W-1:0] GRP_ONE = MVL_W'(1);
  localparam logic [SUB_W-1:0] SUB_ONE = SUB_W'(1);

  logic [REQ_W-1:0] reqSel;
  logic [MVL_W-1:0] clampLen;
  logic [NGRP-1:0]  predReg;

  always_comb begin
    case (srcSel)
      2'd1:    reqSel = regLen;
      2'd2:    reqSel = ctrLen;
      default: reqSel = immLen;
    endcase
    clampLen = (reqSel > {{PAD{1'b0}}, immMaxLen}) ? immMaxLen : reqSel[MVL_W-1:0];
  end

  assign lenZero   = (curLen == '0);
  assign lastSub   = (elemSub == subLen);
  assign lastGrp   = (elemGroup == curLen - GRP_ONE);
  assign elemValid = busy && predReg[elemGroup];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxLen      <= '0;
      curLen      <= '0;
      subLen      <= '0;
      resultValid <= 1'b0;
      resultLen   <= '0;
      elemGroup   <= '0;
      elemSub     <= '0;
      predReg     <= '0;
    end else begin
      resultValid <= strobe.setLoad;
      if (strobe.setLoad) begin
        maxLen    <= immMaxLen;
        subLen    <= immSubLen;
        curLen    <= clampLen;
        resultLen <= {{PAD{1'b0}}, clampLen};
      end
      if (strobe.wrMax) begin
        maxLen <= stateWrMax;
        if (curLen > stateWrMax) curLen <= stateWrMax;
      end
      if (strobe.loopInit) begin
        elemGroup <= '0;
        elemSub   <= '0;
        predReg   <= predMask;
      end
      if (strobe.subInc) elemSub <= elemSub + SUB_ONE;
      if (strobe.grpInc) begin
        elemSub   <= '0;
        elemGroup <= elemGroup + GRP_ONE;
      end
    end
  end

  a_r3_vl_le_mvl: assert property (@(posedge clk) disable iff (!rstN)
    curLen <= maxLen);
  a_r5_result_match: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (resultLen == {{PAD{1'b0}}, curLen}));
  a_r7_sub_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (elemSub <= subLen) && (elemGroup < curLen));
  a_r8_valid_gated: assert property (@(posedge clk) disable iff (!rstN)
    elemValid |-> busy);
  a_r11_state_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(maxLen) && $stable(curLen) && $stable(subLen)));
endmodule

// File: rtl/vec_len_seq.sv
module vec_len_seq
  import vls_pkg::*;
#(
  parameter int MVL_W = 7,
  parameter int REQ_W = 16,
  parameter int SUB_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  setCmd,
  input  logic [1:0]            srcSel,
  input  logic [REQ_W-1:0]      immLen,
  input  logic [REQ_W-1:0]      regLen,
  input  logic [REQ_W-1:0]      ctrLen,
  input  logic [MVL_W-1:0]      immMaxLen,
  input  logic [SUB_W-1:0]      immSubLen,
  input  logic                  stateWrEn,
  input  logic [MVL_W-1:0]      stateWrMax,
  input  logic                  start,
  input  logic [(1<<MVL_W)-1:0] predMask,
  output logic [MVL_W-1:0]      maxLen,
  output logic [MVL_W-1:0]      curLen,
  output logic [SUB_W-1:0]      subLen,
  output logic                  resultValid,
  output logic [REQ_W-1:0]      resultLen,
  output logic                  busy,
  output logic                  done,
  output logic                  elemValid,
  output logic [MVL_W-1:0]      elemGroup,
  output logic [SUB_W-1:0]      elemSub
);
  ctrlStrobe_t strobe;
  logic lenZero, lastSub, lastGrp;

  vls_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .setCmd(setCmd), .start(start), .stateWrEn(stateWrEn),
    .lenZero(lenZero), .lastSub(lastSub), .lastGrp(lastGrp),
    .strobe(strobe), .busy(busy), .done(done)
  );

  vls_dp #(.MVL_W(MVL_W), .REQ_W(REQ_W), .SUB_W(SUB_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .srcSel(srcSel),
    .immLen(immLen), .regLen(regLen), .ctrLen(ctrLen), .immMaxLen(immMaxLen),
    .immSubLen(immSubLen), .stateWrMax(stateWrMax), .predMask(predMask),
    .maxLen(maxLen), .curLen(curLen), .subLen(subLen), .resultValid(resultValid),
    .resultLen(resultLen), .elemGroup(elemGroup), .elemSub(elemSub),
    .elemValid(elemValid), .lenZero(lenZero), .lastSub(lastSub), .lastGrp(lastGrp)
  );
endmodule

// File: tb/vec_len_seq_tb.sv
module vec_len_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MVL_W = 7;
  localparam int REQ_W = 16;
  localparam int SUB_W = 2;
  localparam int NGRP  = 1 << MVL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setCmd = 1'b0, stateWrEn = 1'b0, start = 1'b0;
  logic [1:0] srcSel = '0;
  logic [REQ_W-1:0] immLen = '0, regLen = '0, ctrLen = '0;
  logic [MVL_W-1:0] immMaxLen = '0, stateWrMax = '0;
  logic [SUB_W-1:0] immSubLen = '0;
  logic [NGRP-1:0] predMask = '0;
  logic [MVL_W-1:0] maxLen, curLen, elemGroup;
  logic [SUB_W-1:0] subLen, elemSub;
  logic resultValid, busy, done, elemValid;
  logic [REQ_W-1:0] resultLen;

  int nChecks = 0;
  int nFail = 0;
  int mMax = 0, mCur = 0, mSub = 0;
  int seedVal;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_len_seq #(.MVL_W(MVL_W), .REQ_W(REQ_W), .SUB_W(SUB_W)) dut_i (
    .clk(clk), .rstN(rstN), .setCmd(setCmd), .srcSel(srcSel), .immLen(immLen),
    .regLen(regLen), .ctrLen(ctrLen), .immMaxLen(immMaxLen), .immSubLen(immSubLen),
    .stateWrEn(stateWrEn), .stateWrMax(stateWrMax), .start(start), .predMask(predMask),
    .maxLen(maxLen), .curLen(curLen), .subLen(subLen), .resultValid(resultValid),
    .resultLen(resultLen), .busy(busy), .done(done), .elemValid(elemValid),
    .elemGroup(elemGroup), .elemSub(elemSub)
  );

  task automatic chkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampF(int req, int mx);
    return (req > mx) ? mx : req;
  endfunction

  function automatic int pickReq(int sel, int a, int b, int c);
    if (sel == 1) return b;
    if (sel == 2) return c;
    return a;
  endfunction

  task automatic doSet(int sel, int a, int b, int c, int mx, int sb);
    int expLen;
    setCmd = 1'b1; srcSel = 2'(sel); immLen = 16'(a); regLen = 16'(b); ctrLen = 16'(c);
    immMaxLen = 7'(mx); immSubLen = 2'(sb);
    @(negedge clk);
    setCmd = 1'b0;
    expLen = clampF(pickReq(sel, a, b, c), mx);
    mMax = mx; mSub = sb; mCur = expLen;
    chkEq("R2 maxLen", int'(maxLen), mMax);
    chkEq("R2 subLen", int'(subLen), mSub);
    chkEq("R3 R4 curLen clamp", int'(curLen), mCur);
    chkEq("R5 resultValid high", int'(resultValid), 1);
    chkEq("R5 resultLen", int'(resultLen), expLen);
    @(negedge clk);
    chkEq("R5 resultValid one cycle", int'(resultValid), 0);
  endtask

  task automatic doWr(int v);
    stateWrEn = 1'b1; stateWrMax = 7'(v);
    @(negedge clk);
    stateWrEn = 1'b0;
    if (mCur > v) mCur = v;
    mMax = v;
    chkEq("R6 maxLen direct", int'(maxLen), mMax);
    chkEq("R6 curLen direct", int'(curLen), mCur);
    chkEq("R6 subLen kept", int'(subLen), mSub);
  endtask

  task automatic clearIn();
    setCmd = 1'b0; stateWrEn = 1'b0; start = 1'b0;
  endtask

  task automatic runLoop(logic [NGRP-1:0] pred, bit junk);
    predMask = pred; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mCur == 0) begin
      chkEq("R10 done after zero start", int'(done), 1);
      chkEq("R10 not busy", int'(busy), 0);
      chkEq("R10 no element", int'(elemValid), 0);
    end else begin
      for (int g = 0; g < mCur; g++) begin
        for (int s = 0; s <= mSub; s++) begin
          chkEq("R7 busy", int'(busy), 1);
          chkEq("R7 elemGroup", int'(elemGroup), g);
          chkEq("R7 elemSub", int'(elemSub), s);
          chkEq("R8 elemValid", int'(elemValid), int'(pred[g]));
          chkEq("R9 no early done", int'(done), 0);
          if (junk) begin
            setCmd = 1'b1; immMaxLen = 7'($urandom); immLen = 16'($urandom);
            immSubLen = 2'($urandom); stateWrEn = 1'b1; stateWrMax = 7'($urandom);
            start = 1'b1; predMask = ~pred;
          end
          @(negedge clk);
        end
      end
      clearIn();
      chkEq("R9 done pulse", int'(done), 1);
      chkEq("R9 busy low at done", int'(busy), 0);
      chkEq("R9 no strobe at done", int'(elemValid), 0);
      chkEq("R11 curLen held", int'(curLen), mCur);
      chkEq("R11 maxLen held", int'(maxLen), mMax);
      chkEq("R11 subLen held", int'(subLen), mSub);
    end
    @(negedge clk);
    chkEq("R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    seedVal = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 maxLen reset", int'(maxLen), 0);
    chkEq("R1 curLen reset", int'(curLen), 0);
    chkEq("R1 subLen reset", int'(subLen), 0);
    chkEq("R1 busy reset", int'(busy), 0);
    chkEq("R1 done reset", int'(done), 0);
    chkEq("R1 resultValid reset", int'(resultValid), 0);
    chkEq("R1 elemValid reset", int'(elemValid), 0);

    doSet(0, 10, 0, 0, 20, 1);
    runLoop({NGRP/2{2'b01}}, 1'b0);
    doSet(1, 1, 16'h0105, 3, 127, 3);
    doSet(1, 1, 16'h0105, 3, 100, 3);
    doSet(2, 90, 90, 5, 127, 0);
    runLoop({NGRP{1'b1}}, 1'b1);
    doSet(3, 9, 50, 60, 127, 2);
    runLoop({NGRP/4{4'b1100}}, 1'b1);
    doSet(0, 40, 0, 0, 0, 1);
    runLoop({NGRP{1'b1}}, 1'b1);
    doSet(0, 127, 0, 0, 127, 3);
    runLoop({NGRP/2{2'b10}}, 1'b1);

    doSet(0, 40, 0, 0, 100, 1);
    doWr(30);
    doWr(60);
    runLoop({NGRP{1'b1}}, 1'b0);

    setCmd = 1'b1; start = 1'b1; srcSel = 2'd0; immLen = 16'd4; immMaxLen = 7'd8; immSubLen = 2'd0;
    @(negedge clk);
    clearIn();
    mMax = 8; mCur = 4; mSub = 0;
    chkEq("R12 set beats start busy", int'(busy), 0);
    chkEq("R12 set applied", int'(curLen), 4);
    @(negedge clk);

    doSet(0, 0, 0, 0, 50, 0);
    start = 1'b1; stateWrEn = 1'b1; stateWrMax = 7'd3;
    @(negedge clk);
    clearIn();
    chkEq("R12 start beats write done", int'(done), 1);
    chkEq("R12 start beats write maxLen", int'(maxLen), 50);
    @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      int sel, a, b, c, mx, sb;
      sel = int'($urandom % 4);
      a = ($urandom % 2) ? int'($urandom % 140) : int'($urandom % 65536);
      b = ($urandom % 2) ? int'($urandom % 140) : int'($urandom % 65536);
      c = ($urandom % 2) ? int'($urandom % 140) : int'($urandom % 65536);
      mx = int'($urandom % 128);
      sb = int'($urandom % 4);
      doSet(sel, a, b, c, mx, sb);
      if ($urandom % 4 == 0) doWr(int'($urandom % 128));
      runLoop({$urandom, $urandom, $urandom, $urandom}, 1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule